// File: doc/BRIEF.md
# Two-Bank Edge/Level Interrupt Controller

This block collects up to 64 interrupt input lines, organised as two banks of 32, and turns them into one interrupt request together with the number of the most urgent pending line. Software programs it through a small word-addressed register window of 0x40 bytes. Each bank has four word registers: a latched-event register, an enable register, a write-one-to-clear acknowledge register and a raw-input register.

Most lines are edge-sensitive. A rising edge on an enabled line latches an event bit, and the event bit stays set until software acknowledges it. A build-time mask marks some lines of each bank as level-sensitive. Those lines count as pending straight from their live input and need no acknowledge. When a line's enable bit is set while its input is already high, no event is recorded. Software must look at the raw-input register to notice such a line.

The register port is a plain single-cycle access: a write happens on the clock edge where `reg_wr` is high, and read data follows the address combinationally. The port has no stream handshake, so there is no back-pressure. The request, line number and valid flag are registered outputs.

Top module: `banked_irq_ctrl`

## Requirements
- R1: Bank 0 (lines 0–31) is decoded at byte offset 0x20 and bank 1 (lines 32–63) at 0x10. Inside a bank the word offsets are +0x0 event, +0x4 enable, +0x8 acknowledge and +0xC raw input. Bit n of a bank register belongs to line 32·bank+n. Every other address reads as zero and ignores writes.
- R2: An event bit becomes 1 one clock after its input goes from 0 to 1 while that line's enable bit is 1.
- R3: Writing the acknowledge register clears every event bit written as 1 and leaves bits written as 0 unchanged. If a new edge and an acknowledge for the same bit land in the same cycle, the bit ends up set.
- R4: The enable register reads back exactly the last value written to it.
- R5: Setting the enable bit of an edge-sensitive line whose input is already high leaves its event bit at 0 and raises no request.
- R6: The raw-input register reads the current input lines. Writes to the event register and to the raw-input register change nothing.
- R7: Level-sensitive lines are those in a per-bank mask. For bank 0 the mask is 0x3FF00000 when `WIDE_LEVEL`=1 and 0x1FF00000 otherwise. Bank 1 uses the same mask when `BANK1_LEVEL`=1 and zero otherwise. A level-sensitive line is pending while its input is 1 and its enable bit is 1, whatever an acknowledge does.
- R8: A line is pending when (event OR (input AND level mask)) AND enable is 1. `irq_req` is the OR of all pending bits, registered one cycle.
- R9: `irq_id` is the highest-numbered pending line, which means bank 1 wins over bank 0 and the higher bit wins within a bank. `irq_id_valid` is 1 exactly when some line is pending. When no line is pending, `irq_id` is 0. Both outputs are registered alongside `irq_req`.
- R10: After reset, all enable bits and all event bits are 0 and `irq_req`, `irq_id_valid` and `irq_id` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 6 | Byte address of the register access |
| reg_wr | input | 1 | Write strobe for this cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| irq_lines | input | 64 | Interrupt inputs, synchronous to `clk` |
| irq_req | output | 1 | Interrupt request to the processor |
| irq_id | output | 6 | Highest pending line number |
| irq_id_valid | output | 1 | `irq_id` holds a pending line |

## Verification
A vector table drives different combinations of active lines and enable masks. The combinations separate the bank-1-first rule from the higher-bit-wins rule, and they show that enable masking hides lines in both banks, including the all-quiet case. Directed sequences raise an edge line before and after it is enabled, which separates the enable quirk from ordinary edge latching. They also acknowledge with mixed ones and zeros and collide an acknowledge with a fresh edge. Level lines are held high across acknowledges, and a non-level line next to the mask boundary is checked against them, which tells level handling apart from edge handling.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned BANK_W   = 32;
  localparam logic [1:0]  SEL_EVT  = 2'd0;
  localparam logic [1:0]  SEL_ENA  = 2'd1;
  localparam logic [1:0]  SEL_ACK  = 2'd2;
  localparam logic [1:0]  SEL_RAW  = 2'd3;

  function automatic logic [BANK_W-1:0] lvl_mask(input int bank, input bit wide, input bit hi_en);
    logic [BANK_W-1:0] base;
    base = wide ? 32'h3FF0_0000 : 32'h1FF0_0000;
    return (bank == 0 || hi_en) ? base : '0;
  endfunction
endpackage

// File: rtl/irqc_bank.sv
module irqc_bank
  import irqc_pkg::*;
#(
  parameter logic [BANK_W-1:0] LMASK = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BANK_W-1:0] lines,
  input  logic              en_we,
  input  logic              ack_we,
  input  logic [BANK_W-1:0] wdata,
  output logic [BANK_W-1:0] event_q,
  output logic [BANK_W-1:0] enable_q,
  output logic [BANK_W-1:0] pending
);
  logic [BANK_W-1:0] prev_q;
  logic [BANK_W-1:0] set_v;
  logic [BANK_W-1:0] clr_v;

  assign set_v   = lines & ~prev_q & enable_q;
  assign clr_v   = ack_we ? wdata : '0;
  assign pending = (event_q | (lines & LMASK)) & enable_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q   <= '0;
      enable_q <= '0;
      event_q  <= '0;
    end else begin
      prev_q  <= lines;
      event_q <= (event_q & ~clr_v) | set_v;
      if (en_we) enable_q <= wdata;
    end
  end

  p_reset_clear_r10: assert property (@(posedge clk)
    !rst_n |=> (enable_q == '0 && event_q == '0));

  p_enable_readback_r4: assert property (@(posedge clk) disable iff (!rst_n)
    en_we |=> enable_q == $past(wdata));

  p_ack_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ack_we |=> (event_q & $past(wdata & ~set_v)) == '0);

  p_event_needs_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((event_q & ~$past(event_q)) & ~$past(lines & ~prev_q & enable_q)) == '0);
endmodule

// File: rtl/irqc_pick.sv
module irqc_pick #(
  parameter int unsigned N    = 64,
  parameter int unsigned ID_W = $clog2(N)
) (
  input  logic [N-1:0]    pend,
  output logic            vld,
  output logic [ID_W-1:0] id
);
  always_comb begin
    vld = 1'b0;
    id  = '0;
    for (int i = 0; i < N; i++) begin
      if (pend[i]) begin
        vld = 1'b1;
        id  = ID_W'(i);
      end
    end
  end

  always_comb begin
    if (vld) begin
      p_pick_is_pending_r9: assert (pend[id]);
    end
  end
endmodule

// File: rtl/banked_irq_ctrl.sv
module banked_irq_ctrl
  import irqc_pkg::*;
#(
  parameter int unsigned NUM_BANKS   = 2,
  parameter bit          WIDE_LEVEL  = 1'b1,
  parameter bit          BANK1_LEVEL = 1'b0,
  localparam int unsigned LINES  = NUM_BANKS * BANK_W,
  localparam int unsigned ID_W   = $clog2(LINES),
  localparam int unsigned ADDR_W = $clog2((NUM_BANKS + 2) * 16)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [BANK_W-1:0] reg_wdata,
  output logic [BANK_W-1:0] reg_rdata,
  input  logic [LINES-1:0]  irq_lines,
  output logic              irq_req,
  output logic [ID_W-1:0]   irq_id,
  output logic              irq_id_valid
);
  localparam int unsigned HI_W = ADDR_W - 4;

  logic [1:0]           reg_sel;
  logic [NUM_BANKS-1:0] hit;
  logic [BANK_W-1:0]    ev  [NUM_BANKS];
  logic [BANK_W-1:0]    ena [NUM_BANKS];
  logic [LINES-1:0]     pend_all;
  logic                 pick_vld;
  logic [ID_W-1:0]      pick_id;

  assign reg_sel = reg_addr[3:2];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam logic [HI_W-1:0] BSEL = HI_W'(NUM_BANKS - b);
    assign hit[b] = (reg_addr[ADDR_W-1:4] == BSEL);

    irqc_bank #(
      .LMASK (lvl_mask(b, WIDE_LEVEL, BANK1_LEVEL))
    ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .lines    (irq_lines[b*BANK_W +: BANK_W]),
      .en_we    (reg_wr && hit[b] && reg_sel == SEL_ENA),
      .ack_we   (reg_wr && hit[b] && reg_sel == SEL_ACK),
      .wdata    (reg_wdata),
      .event_q  (ev[b]),
      .enable_q (ena[b]),
      .pending  (pend_all[b*BANK_W +: BANK_W])
    );
  end

  always_comb begin
    reg_rdata = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (hit[b]) begin
        case (reg_sel)
          SEL_EVT: reg_rdata = ev[b];
          SEL_ENA: reg_rdata = ena[b];
          SEL_RAW: reg_rdata = irq_lines[b*BANK_W +: BANK_W];
          default: reg_rdata = '0;
        endcase
      end
    end
  end

  irqc_pick #(.N(LINES), .ID_W(ID_W)) u_pick (
    .pend (pend_all),
    .vld  (pick_vld),
    .id   (pick_id)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_req      <= 1'b0;
      irq_id_valid <= 1'b0;
      irq_id       <= '0;
    end else begin
      irq_req      <= |pend_all;
      irq_id_valid <= pick_vld;
      irq_id       <= pick_vld ? pick_id : '0;
    end
  end

  p_req_tracks_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq_req == $past(|pend_all));

  p_id_zero_when_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_id_valid |-> irq_id == '0);

  p_outputs_reset_r10: assert property (@(posedge clk)
    !rst_n |=> (!irq_req && !irq_id_valid));
endmodule

// File: tb/test_banked_irq_ctrl.sv
module test_banked_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [63:0] irq_lines = '0;
  logic        irq_req;
  logic [5:0]  irq_id;
  logic        irq_id_valid;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  banked_irq_ctrl i_banked_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_lines(irq_lines),
    .irq_req(irq_req), .irq_id(irq_id), .irq_id_valid(irq_id_valid)
  );

  // Bank 0 at 0x20, bank 1 at 0x10 (R1)
  localparam logic [5:0] B0_EVT = 6'h20, B0_ENA = 6'h24, B0_ACK = 6'h28, B0_RAW = 6'h2C;
  localparam logic [5:0] B1_EVT = 6'h10, B1_ENA = 6'h14, B1_ACK = 6'h18, B1_RAW = 6'h1C;

  typedef struct packed {
    logic [63:0] lines;
    logic [63:0] en;
    logic        vld;
    logic [5:0]  id;
  } vec_t;

  localparam vec_t VECS [0:7] = '{
    '{64'h0000_0000_0000_0020, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 6'd5},
    '{64'h0000_0100_0000_0008, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 6'd40},
    '{64'h8000_0000_0000_0001, 64'h0000_0000_0000_0001, 1'b1, 6'd0},
    '{64'h0000_0000_8000_0400, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 6'd31},
    '{64'h0000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 6'd0},
    '{64'h0000_0003_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 6'd33},
    '{64'h0000_0000_0200_0000, 64'h0000_0000_0200_0000, 1'b1, 6'd25},
    '{64'h0004_0000_0000_0000, 64'h0002_0000_0000_0000, 1'b0, 6'd0}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wr = 1'b0;
    #1 d = reg_rdata;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic quiesce();
    wr(B0_ENA, '0); wr(B1_ENA, '0);
    @(negedge clk); irq_lines = '0;
    wait_cyc(1);
    wr(B0_ACK, '1); wr(B1_ACK, '1);
    wait_cyc(2);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog (R1..all): actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    wait_cyc(3);
    @(negedge clk); rst_n = 1'b1;

    // R10 reset state
    wait_cyc(1);
    chk("R10 irq_req", {63'd0, irq_req}, 64'd0);
    chk("R10 valid", {63'd0, irq_id_valid}, 64'd0);
    chk("R10 id", {58'd0, irq_id}, 64'd0);
    rd(B0_ENA, d); chk("R10 enable0", {32'd0, d}, 64'd0);
    rd(B1_EVT, d); chk("R10 event1", {32'd0, d}, 64'd0);

    // Vector table walk: R8, R9
    for (int i = 0; i < 8; i++) begin
      vec_t v;
      v = VECS[i];
      quiesce();
      wr(B0_ENA, v.en[31:0]); wr(B1_ENA, v.en[63:32]);
      @(negedge clk); irq_lines = v.lines;
      wait_cyc(3);
      chk("R8 irq_req", {63'd0, irq_req}, {63'd0, v.vld});
      chk("R9 valid", {63'd0, irq_id_valid}, {63'd0, v.vld});
      chk("R9 id", {58'd0, irq_id}, {58'd0, v.id});
    end

    // R4 enable readback and R1 bank separation / unmapped
    quiesce();
    wr(B0_ENA, 32'hA5A5_0F0F); wr(B1_ENA, 32'h1234_5678);
    wr(6'h04, 32'hFFFF_FFFF); wr(6'h34, 32'hFFFF_FFFF);
    rd(B0_ENA, d); chk("R4 enable0 readback", {32'd0, d}, 64'hA5A5_0F0F);
    rd(B1_ENA, d); chk("R4 enable1 readback", {32'd0, d}, 64'h1234_5678);
    rd(6'h04, d);  chk("R1 unmapped read", {32'd0, d}, 64'd0);
    rd(B0_ACK, d); chk("R1 ack reads zero", {32'd0, d}, 64'd0);

    // R5 enabling a line that is already high
    quiesce();
    @(negedge clk); irq_lines[7] = 1'b1;
    wait_cyc(2);
    wr(B0_ENA, 32'h0000_0080);
    wait_cyc(3);
    rd(B0_EVT, d); chk("R5 no event on enable", {32'd0, d}, 64'd0);
    chk("R5 no request", {63'd0, irq_req}, 64'd0);
    // R2 a real edge while enabled
    @(negedge clk); irq_lines[7] = 1'b0;
    @(negedge clk); irq_lines[7] = 1'b1;
    wait_cyc(2);
    chk("R2 request", {63'd0, irq_req}, 64'd1);
    chk("R2 id", {58'd0, irq_id}, 64'd7);
    rd(B0_EVT, d); chk("R2 event latched", {32'd0, d}, 64'h80);
    // R3 acknowledge
    wr(B0_ACK, 32'h0000_0001);
    rd(B0_EVT, d); chk("R3 zero bits untouched", {32'd0, d}, 64'h80);
    wr(B0_ACK, 32'h0000_0080);
    wait_cyc(1);
    rd(B0_EVT, d); chk("R3 ack clears", {32'd0, d}, 64'd0);
    chk("R3 request drops", {63'd0, irq_req}, 64'd0);
    // R3 set wins over same-cycle ack
    wr(B0_ENA, 32'h0000_0100);
    @(negedge clk);
    irq_lines[8] = 1'b1;
    reg_addr = B0_ACK; reg_wdata = 32'h0000_0100; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
    rd(B0_EVT, d); chk("R3 set wins", {32'd0, d}, 64'h100);

    // R7 level lines
    quiesce();
    @(negedge clk);
    irq_lines[22] = 1'b1; irq_lines[30] = 1'b1; irq_lines[52] = 1'b1;
    wait_cyc(2);
    wr(B0_ENA, 32'h4040_0000); wr(B1_ENA, 32'h0010_0000);
    wait_cyc(3);
    chk("R7 level pending", {63'd0, irq_req}, 64'd1);
    chk("R7 level id (line 30 and 52 edge-only)", {58'd0, irq_id}, 64'd22);
    rd(B1_EVT, d); chk("R5 bank1 no event", {32'd0, d}, 64'd0);
    wr(B0_ACK, 32'hFFFF_FFFF);
    wait_cyc(2);
    chk("R7 ack has no effect", {58'd0, irq_id}, 64'd22);
    @(negedge clk); irq_lines[22] = 1'b0;
    wait_cyc(2);
    chk("R7 level released", {63'd0, irq_req}, 64'd0);

    // R6 raw input register, read-only event/raw
    quiesce();
    @(negedge clk); irq_lines = 64'h8000_0001_0000_0080;
    wait_cyc(1);
    wr(B0_EVT, 32'hFFFF_FFFF); wr(B0_RAW, 32'h0000_FFFF);
    rd(B0_EVT, d); chk("R6 event write ignored", {32'd0, d}, 64'd0);
    rd(B0_RAW, d); chk("R6 raw bank0", {32'd0, d}, 64'h80);
    rd(B1_RAW, d); chk("R6 raw bank1", {32'd0, d}, 64'h8000_0001);
    chk("R6 no request", {63'd0, irq_req}, 64'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule